// File: doc/BRIEF.md
# Input Edge Counting Timer

A 16-bit down-counter driven by transitions on an external capture pin rather than by the clock. The pin first passes through a two-stage synchroniser, and a programmable edge qualifier turns the synchronised level into single-cycle events. In edge-count mode every qualifying event takes one off the counter. When the next value would equal a programmed match value, the counter reloads from an interval register instead and a status flag sets, so counting restarts with no software help.

In edge-time mode the same counter runs freely, one step per clock, and wraps back to the interval value after reaching zero. Each qualifying event copies the running count into a capture register and raises a second flag. Software drives the block through a single-cycle write port and a combinational read port. The interrupt line is the OR of the status flags gated by a mask.

Top module: `edge_cnt_timer`

## Requirements
- R1: After reset, the registers read as follows. Control is 0. Interval and counter are 0xFFFF. Match, mask, capture and both status views are 0. The interrupt is low.
- R2: In edge-count mode with the timer enabled, each qualifying event lowers the counter by one. A level change on the capture pin that is present at one rising clock edge shows up in the counter after the third rising edge, counting that edge as the first.
- R3: The edge field is control bits [3:2]. A value of 00 qualifies rising edges. A value of 01 qualifies falling edges. A value of 11 qualifies both. A value of 10 qualifies none, and the pin then has no effect on counter, capture or status.
- R4: In edge-count mode, an event whose decremented value would equal the match register instead reloads the counter from the interval register and sets raw status bit 0.
- R5: While the enable bit is clear, the counter holds its value exactly. Pin events are ignored. Clearing the enable bit causes no additional decrement.
- R6: In edge-time mode with the timer enabled, the counter steps down by one every clock and reloads from the interval register when it is 0. A qualifying event copies the counter's value from before that clock into the capture register and sets raw status bit 1.
- R7: Raw status bits set whether or not they are masked. The interrupt is high when any status bit is set together with its mask bit. Writing 1s to address 4 clears the matching status bits. If a status bit sets and is cleared in the same cycle, the set wins.
- R8: A write to the interval register while the timer is disabled also loads the counter. While the timer is enabled, the same write leaves the counter untouched.
- R9: The register map is as follows. Address 0 is control: bit 0 enable, bit 1 mode (0 count, 1 time), bits [3:2] edge. Address 1 is the interval. Address 2 is the match. Address 3 is the mask: bit 0 match, bit 1 capture. Address 4 is raw status on read and the clear register on write. Address 5 is the counter, read-only. Address 6 is the capture register, read-only. Address 7 is masked status, read-only. Writes take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| cap_in | input | 1 | Asynchronous capture pin |
| irq | output | 1 | Masked interrupt |

## Verification
The pin is driven with isolated pulses of several widths under each edge setting, including the none setting, so that rising-only, falling-only and both-edge counting produce different counts from the same waveform. One run of pulses is placed so the counter crosses the match value, which separates reload-at-match from a plain decrement or a wrap at zero. Further pulses arrive just before and after the enable bit is cleared, which exposes any extra step on disabling. Edge-time runs use a short interval so that zero-wrap reloads and captures interleave. The read address sweeps all eight registers on every clock, so every register and the interrupt line are compared against the reference model throughout.

// File: rtl/ect_pkg.sv
package ect_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_LOAD  = 3'd1,
        A_MATCH = 3'd2,
        A_MASK  = 3'd3,
        A_STAT  = 3'd4,
        A_COUNT = 3'd5,
        A_CAPT  = 3'd6,
        A_MSTAT = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_OFF  = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_TIME  = 1'b1
    } tmr_mode_e;

    localparam int NUM_FLAGS = 2;   // bit 0 match, bit 1 capture

endpackage

// File: rtl/ect_sync_edge.sv
module ect_sync_edge
    import ect_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cap_in,
    input  edge_sel_e sel,
    output logic      evt
);

    localparam int PIPE_W = STAGES + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] pipe;
    } sync_s;

    sync_s q, d;
    logic  cur, prev;

    always_comb begin
        d      = q;
        d.pipe = {q.pipe[PIPE_W-2:0], cap_in};
        cur    = q.pipe[STAGES-1];
        prev   = q.pipe[STAGES];
        unique case (sel)
            EDGE_RISE: evt = cur & ~prev;
            EDGE_FALL: evt = ~cur & prev;
            EDGE_BOTH: evt = cur ^ prev;
            default:   evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/ect_regs.sv
module ect_regs
    import ect_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [W-1:0]         wr_data,
    input  logic                 match_hit,
    input  logic                 cap_hit,
    output logic                 enable,
    output tmr_mode_e            mode,
    output edge_sel_e            esel,
    output logic [W-1:0]         load,
    output logic [W-1:0]         match,
    output logic [NUM_FLAGS-1:0] mask,
    output logic [NUM_FLAGS-1:0] status,
    output logic                 load_now,
    output logic                 irq
);

    typedef struct packed {
        logic                 en;
        tmr_mode_e            mode;
        edge_sel_e            esel;
        logic [W-1:0]         load;
        logic [W-1:0]         match;
        logic [NUM_FLAGS-1:0] mask;
        logic [NUM_FLAGS-1:0] status;
    } regs_s;

    regs_s                q, d;
    logic [NUM_FLAGS-1:0] clr;
    logic [NUM_FLAGS-1:0] set;

    always_comb begin
        d        = q;
        clr      = '0;
        load_now = 1'b0;
        set      = {cap_hit, match_hit};
        if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                A_CTRL: begin
                    d.en   = wr_data[0];
                    d.mode = tmr_mode_e'(wr_data[1]);
                    d.esel = edge_sel_e'(wr_data[3:2]);
                end
                A_LOAD: begin
                    d.load   = wr_data;
                    load_now = ~q.en;
                end
                A_MATCH: d.match = wr_data;
                A_MASK:  d.mask  = wr_data[NUM_FLAGS-1:0];
                A_STAT:  clr     = wr_data[NUM_FLAGS-1:0];
                default: ;
            endcase
        end
        d.status = (q.status & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.en     <= 1'b0;
            q.mode   <= MODE_COUNT;
            q.esel   <= EDGE_RISE;
            q.load   <= '1;
            q.match  <= '0;
            q.mask   <= '0;
            q.status <= '0;
        end else begin
            q <= d;
        end
    end

    assign enable = q.en;
    assign mode   = q.mode;
    assign esel   = q.esel;
    assign load   = q.load;
    assign match  = q.match;
    assign mask   = q.mask;
    assign status = q.status;
    assign irq    = |(q.status & q.mask);

endmodule

// File: rtl/ect_counter.sv
module ect_counter
    import ect_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  tmr_mode_e    mode,
    input  logic         evt,
    input  logic [W-1:0] load,
    input  logic [W-1:0] match,
    input  logic         load_now,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic [W-1:0] capture,
    output logic         match_hit,
    output logic         cap_hit
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] capture;
    } cnt_s;

    cnt_s         q, d;
    logic [W-1:0] dec;

    always_comb begin
        d         = q;
        match_hit = 1'b0;
        cap_hit   = 1'b0;
        dec       = q.count - ONE;
        if (load_now) begin
            d.count = load_val;
        end else if (enable) begin
            if (mode == MODE_COUNT) begin
                if (evt) begin
                    if (dec == match) begin
                        d.count   = load;
                        match_hit = 1'b1;
                    end else begin
                        d.count = dec;
                    end
                end
            end else begin
                d.count = (q.count == '0) ? load : dec;
                if (evt) begin
                    d.capture = q.count;
                    cap_hit   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.count   <= '1;
            q.capture <= '0;
        end else begin
            q <= d;
        end
    end

    assign count   = q.count;
    assign capture = q.capture;

endmodule

// File: rtl/edge_cnt_timer.sv
module edge_cnt_timer
    import ect_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              cap_in,
    output logic              irq
);

    localparam int PAD = W - NUM_FLAGS;

    logic                 en_w;
    tmr_mode_e            mode_w;
    edge_sel_e            esel_w;
    logic [W-1:0]         load_w;
    logic [W-1:0]         match_w;
    logic [NUM_FLAGS-1:0] mask_w;
    logic [NUM_FLAGS-1:0] status_w;
    logic                 load_now_w;
    logic                 evt_w;
    logic [W-1:0]         count_w;
    logic [W-1:0]         capt_w;
    logic                 hit_w;
    logic                 caphit_w;

    ect_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_in (cap_in),
        .sel    (esel_w),
        .evt    (evt_w)
    );

    ect_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .match_hit (hit_w),
        .cap_hit   (caphit_w),
        .enable    (en_w),
        .mode      (mode_w),
        .esel      (esel_w),
        .load      (load_w),
        .match     (match_w),
        .mask      (mask_w),
        .status    (status_w),
        .load_now  (load_now_w),
        .irq       (irq)
    );

    ect_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (en_w),
        .mode      (mode_w),
        .evt       (evt_w),
        .load      (load_w),
        .match     (match_w),
        .load_now  (load_now_w),
        .load_val  (wr_data),
        .count     (count_w),
        .capture   (capt_w),
        .match_hit (hit_w),
        .cap_hit   (caphit_w)
    );

    always_comb begin
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            A_CTRL:  rd_data = {{(W-4){1'b0}}, esel_w, mode_w, en_w};
            A_LOAD:  rd_data = load_w;
            A_MATCH: rd_data = match_w;
            A_MASK:  rd_data = {{PAD{1'b0}}, mask_w};
            A_STAT:  rd_data = {{PAD{1'b0}}, status_w};
            A_COUNT: rd_data = count_w;
            A_CAPT:  rd_data = capt_w;
            A_MSTAT: rd_data = {{PAD{1'b0}}, status_w & mask_w};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ect_chk.sv
module ect_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         mode,
    input logic [1:0]   esel,
    input logic         evt,
    input logic         load_now,
    input logic [W-1:0] load,
    input logic [W-1:0] count,
    input logic [W-1:0] capture,
    input logic         match_hit,
    input logic [1:0]   status,
    input logic [1:0]   mask,
    input logic         irq
);

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load_now) |=> $stable(count)); // R5

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mode && evt && !match_hit) |=> (count == W'($past(count) - 1'b1))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mode && !evt) |=> $stable(count)); // R2

    AST_MATCH_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> (count == $past(load))); // R4

    AST_RAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> status[0]); // R7

    AST_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (esel == 2'b10) |-> !evt); // R3

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode && evt) |=> ((capture == $past(count)) && status[1])); // R6

    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode && (count != '0)) |=> (count == W'($past(count) - 1'b1))); // R6

    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b00) |-> !irq); // R7

endmodule

bind edge_cnt_timer ect_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_w),
    .mode      (mode_w),
    .esel      (esel_w),
    .evt       (evt_w),
    .load_now  (load_now_w),
    .load      (load_w),
    .count     (count_w),
    .capture   (capt_w),
    .match_hit (hit_w),
    .status    (status_w),
    .mask      (mask_w),
    .irq       (irq)
);

// File: tb/edge_cnt_timer_tb.sv
module edge_cnt_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cap_in = 1'b0;
    logic        irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference state
    bit          m_en, m_mode;
    logic [1:0]  m_esel;
    logic [15:0] m_load, m_match, m_cnt, m_capv;
    logic [1:0]  m_mask, m_st;
    bit          pin_hist[$];

    always #5 clk = ~clk;

    edge_cnt_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cap_in  (cap_in),
        .irq     (irq)
    );

    function automatic void model_reset();
        m_en = 0; m_mode = 0; m_esel = 2'b00;
        m_load = 16'hFFFF; m_match = 16'h0; m_cnt = 16'hFFFF; m_capv = 16'h0;
        m_mask = 2'b00; m_st = 2'b00;
        pin_hist = {};
        for (int i = 0; i < 4; i++) pin_hist.push_back(1'b0);
    endfunction

    function automatic logic [15:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {12'h0, m_esel, m_mode, m_en};
            3'd1: return m_load;
            3'd2: return m_match;
            3'd3: return {14'h0, m_mask};
            3'd4: return {14'h0, m_st};
            3'd5: return m_cnt;
            3'd6: return m_capv;
            default: return {14'h0, m_st & m_mask};
        endcase
    endfunction

    initial model_reset();

    // behavioural reference, advanced at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit now_lvl, old_lvl, ev;
            logic [1:0] setb, clrb;
            bit old_en;
            now_lvl = pin_hist[1];
            old_lvl = pin_hist[2];
            case (m_esel)
                2'b00: ev = now_lvl && !old_lvl;
                2'b01: ev = !now_lvl && old_lvl;
                2'b11: ev = now_lvl != old_lvl;
                default: ev = 0;
            endcase
            setb = 2'b00;
            clrb = 2'b00;
            old_en = m_en;
            if (m_en) begin
                if (!m_mode) begin
                    if (ev) begin
                        if (m_cnt - 16'd1 == m_match) begin
                            m_cnt = m_load;
                            setb[0] = 1;
                        end else begin
                            m_cnt = m_cnt - 16'd1;
                        end
                    end
                end else begin
                    if (ev) begin
                        m_capv = m_cnt;
                        setb[1] = 1;
                    end
                    m_cnt = (m_cnt == 16'd0) ? m_load : m_cnt - 16'd1;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_en = wr_data[0]; m_mode = wr_data[1]; m_esel = wr_data[3:2]; end
                    3'd1: begin m_load = wr_data; if (!old_en) m_cnt = wr_data; end
                    3'd2: m_match = wr_data;
                    3'd3: m_mask = wr_data[1:0];
                    3'd4: clrb = wr_data[1:0];
                    default: ;
                endcase
            end
            m_st = (m_st & ~clrb) | setb;
            pin_hist.push_front(cap_in);
            void'(pin_hist.pop_back());
        end
        started = 1;
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic [15:0] exp_rd;
            bit exp_irq;
            exp_rd  = model_read(rd_addr);
            exp_irq = |(m_st & m_mask);
            n_cmp++;
            if (rd_data !== exp_rd || irq !== exp_irq) begin
                n_bad++;
                $display("FAIL %s addr=%0d actual rd=%h irq=%b expected rd=%h irq=%b",
                         cur_req, rd_addr, rd_data, irq, exp_rd, exp_irq);
            end
        end
    end

    // read address sweeps every register
    always @(posedge clk) begin
        #2;
        rd_addr <= rd_addr + 3'd1;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            summary();
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(posedge clk); #2;
        wr_en = 1; wr_addr = a; wr_data = v;
        @(posedge clk); #2;
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        @(posedge clk); #2;
        cap_in = 1;
        repeat (hi) @(posedge clk);
        #2;
        cap_in = 0;
        repeat (lo) @(posedge clk);
    endtask

    initial begin
        cur_req = "R1";
        idle(4);
        @(posedge clk); #2;
        rst_n = 1;
        idle(16);                       // R1 reset values swept

        cur_req = "R9";
        wr(3'd2, 16'h0005);
        wr(3'd3, 16'h0000);
        idle(10);

        cur_req = "R8";                 // disabled load also loads counter
        wr(3'd1, 16'h0010);
        idle(10);

        cur_req = "R2";                 // rising edges, count mode
        wr(3'd0, 16'h0001);
        for (int i = 0; i < 3; i++) pulse(3, 4);
        pulse(1, 6);
        idle(8);

        cur_req = "R3";                 // falling, both, none
        wr(3'd0, 16'h0005);
        for (int i = 0; i < 2; i++) pulse(2, 5);
        wr(3'd0, 16'h000D);
        for (int i = 0; i < 2; i++) pulse(4, 3);
        wr(3'd0, 16'h0009);
        for (int i = 0; i < 3; i++) pulse(3, 3);
        idle(8);

        cur_req = "R4";                 // match reload
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h000A);
        wr(3'd2, 16'h0007);
        wr(3'd3, 16'h0001);
        wr(3'd0, 16'h0001);
        for (int i = 0; i < 5; i++) pulse(2, 4);
        idle(8);

        cur_req = "R7";                 // masking and clearing
        wr(3'd3, 16'h0000);
        idle(8);
        wr(3'd3, 16'h0003);
        idle(4);
        wr(3'd4, 16'h0001);
        idle(8);
        for (int i = 0; i < 4; i++) pulse(2, 4);
        wr(3'd4, 16'h0003);
        idle(6);

        cur_req = "R5";                 // freeze on disable
        pulse(2, 1);
        wr(3'd0, 16'h0000);
        for (int i = 0; i < 3; i++) pulse(2, 3);
        idle(10);
        wr(3'd0, 16'h000D);
        pulse(3, 2);
        wr(3'd0, 16'h000C);
        idle(10);

        cur_req = "R8";                 // enabled load leaves counter
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h0040);
        idle(10);

        cur_req = "R6";                 // time mode, wrap and capture
        wr(3'd1, 16'h0014);
        wr(3'd0, 16'h0003);
        for (int i = 0; i < 6; i++) pulse(3, 7);
        idle(40);
        wr(3'd4, 16'h0002);
        wr(3'd0, 16'h000F);
        for (int i = 0; i < 4; i++) pulse(5, 6);
        wr(3'd0, 16'h0002);
        idle(12);

        done = 1;
        summary();
    end

endmodule